// File: doc/BRIEF.md
# Clock Generator Power-Up Sequencer

This block brings a clock generator from power-off to normal running. It watches a supply-valid flag, an active-low termination power-good pin and two frequency-select strap pins. All four pins arrive from outside the clock domain and first pass through a two-flop synchroniser.

Once the supply is valid, the sequencer enables the VCO and waits in a holding state. It leaves that state only when a minimum settle time has elapsed and power-good is asserted (low). It then captures the straps, announces the capture with a one-cycle strobe, and waits a fixed lock interval. After that interval it raises the output enable.

In the running state the power-good pin and the straps are no longer consulted. Only loss of supply returns the block to the off state, and that also clears the captured straps. Both delays are parameters counted in reference-clock cycles. At 100 MHz the defaults correspond to 0.25 ms and 1.146 ms.

Top module: `clkgen_powerup_seq`

## Requirements
- R1: During reset and in the off state (`seq_state` = 0), `vco_en`, `outs_en`, `strap_strobe` and `strap_val` are all 0.
- R2: `vco_en` is 1 in every state other than off, from the very cycle the waiting state (`seq_state` = 1) is entered.
- R3: Entry to the sampling state (`seq_state` = 2) raises `strap_strobe` for exactly one cycle. In that same cycle `strap_val[0]` holds the synchronised `strap_a` and `strap_val[1]` holds the synchronised `strap_b`, and these values are then held.
- R4: The state advances only by one step (0→1→2→3) or returns to 0. The waiting state lasts exactly max(`SETTLE_CYC`, cycles until the synchronised `pwrgd_n` reads 0) cycles after entry, and never fewer than `SETTLE_CYC`.
- R5: The sampling state lasts exactly `LOCK_CYC` cycles before the running state (`seq_state` = 3). `outs_en` is 1 only in the running state.
- R6: In the running state, changes on `pwrgd_n`, `strap_a` and `strap_b` do not affect `seq_state`, `outs_en` or `strap_val`.
- R7: When the supply flag drops, the block goes to off from any state and `strap_val` is cleared to 0.
- R8: A change on `supply_ok` or `pwrgd_n` applied between edges takes effect on the state at the third following clock edge (two synchroniser flops plus the state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Core supply valid, asynchronous |
| pwrgd_n | input | 1 | Termination power-good, active low, asynchronous |
| strap_a | input | 1 | Frequency-select strap, bit 0 |
| strap_b | input | 1 | Frequency-select strap, bit 1 |
| vco_en | output | 1 | VCO enable, registered |
| strap_strobe | output | 1 | One-cycle pulse when the straps are captured |
| strap_val | output | 2 | Captured straps {b, a} |
| outs_en | output | 1 | Clock output enable, registered |
| seq_state | output | 2 | Current state: 0 off, 1 wait, 2 sample, 3 run |

## Verification
The assertions assume that reset is held for at least one edge before it is released, so that the state register is known when `$past` is first consulted. They also assume that `SETTLE_CYC` and `LOCK_CYC` are at least 1.

The bench drives every input change on the falling edge, so each change meets the synchroniser cleanly. It sweeps all four strap combinations against power-good arrival times before, at and after the settle boundary. It also drops the supply in the waiting state, in the sampling state and inside the synchroniser window, and in each case computes the expected state per cycle from the edge counts in R4, R5 and R8.

// File: rtl/clkgen_seq_pkg.sv
package clkgen_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_OFF     = 2'd0,
    SEQ_WAIT_PG = 2'd1,
    SEQ_SAMPLE  = 2'd2,
    SEQ_RUN     = 2'd3
  } seq_state_t;

  localparam int unsigned STRAP_W = 2;

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/clkgen_delay_timer.sv
module clkgen_delay_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/clkgen_strap_latch.sv
module clkgen_strap_latch #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (cap) begin
      q <= d;
    end
  end

endmodule

// File: rtl/clkgen_powerup_seq.sv
module clkgen_powerup_seq
  import clkgen_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 25000,
  parameter int unsigned LOCK_CYC   = 114600,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               supply_ok,
  input  logic               pwrgd_n,
  input  logic               strap_a,
  input  logic               strap_b,
  output logic               vco_en,
  output logic               strap_strobe,
  output logic [STRAP_W-1:0] strap_val,
  output logic               outs_en,
  output logic [1:0]         seq_state
);

  localparam int unsigned MAX_CYC = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LD   = CNT_W'(LOCK_CYC - 1);
  localparam int unsigned IN_W = 2 + STRAP_W;

  // synchronised inputs: {strap_b, strap_a, pwrgd_n, supply_ok}
  logic [IN_W-1:0] in_raw, in_s;
  logic supply_s, pgn_s;
  logic [STRAP_W-1:0] straps_s;

  assign in_raw = {strap_b, strap_a, pwrgd_n, supply_ok};

  clkgen_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(IN_W'(4'b0010))
  ) i_sync (
    .clk(clk),
    .rst(rst),
    .d  (in_raw),
    .q  (in_s)
  );

  assign supply_s = in_s[0];
  assign pgn_s    = in_s[1];
  assign straps_s = in_s[IN_W-1:2];

  seq_state_t state_q, state_nx;
  logic tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic take_straps;

  clkgen_delay_timer #(.CNT_W(CNT_W)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  // next-state and timer control
  always_comb begin
    state_nx    = state_q;
    tmr_load    = 1'b0;
    tmr_val     = SETTLE_LD;
    take_straps = 1'b0;
    if (!supply_s) begin
      state_nx = SEQ_OFF;
    end else begin
      unique case (state_q)
        SEQ_OFF: begin
          state_nx = SEQ_WAIT_PG;
          tmr_load = 1'b1;
          tmr_val  = SETTLE_LD;
        end
        SEQ_WAIT_PG: begin
          if (tmr_done && !pgn_s) begin
            state_nx    = SEQ_SAMPLE;
            tmr_load    = 1'b1;
            tmr_val     = LOCK_LD;
            take_straps = 1'b1;
          end
        end
        SEQ_SAMPLE: begin
          if (tmr_done) state_nx = SEQ_RUN;
        end
        SEQ_RUN: begin
          state_nx = SEQ_RUN;
        end
        default: state_nx = SEQ_OFF;
      endcase
    end
  end

  clkgen_strap_latch #(.W(STRAP_W)) i_straps (
    .clk(clk),
    .rst(rst),
    .clr(state_nx == SEQ_OFF),
    .cap(take_straps),
    .d  (straps_s),
    .q  (strap_val)
  );

  // registered state and outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= SEQ_OFF;
      vco_en       <= 1'b0;
      outs_en      <= 1'b0;
      strap_strobe <= 1'b0;
    end else begin
      state_q      <= state_nx;
      vco_en       <= (state_nx != SEQ_OFF);
      outs_en      <= (state_nx == SEQ_RUN);
      strap_strobe <= take_straps;
    end
  end

  assign seq_state = state_q;

endmodule

// File: rtl/clkgen_powerup_seq_chk.sv
module clkgen_powerup_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       supply_s,
  input logic       vco_en,
  input logic       outs_en,
  input logic       strap_strobe,
  input logic [1:0] strap_val,
  input logic [1:0] seq_state
);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 2'd0) |-> (!vco_en && !outs_en && !strap_strobe)); // R1

  AST_VCO_ON: assert property (@(posedge clk) disable iff (rst)
    (seq_state != 2'd0) |-> vco_en); // R2

  AST_STROBE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    strap_strobe |-> (seq_state == 2'd2 && $past(seq_state) == 2'd1)); // R3

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strap_strobe && seq_state != 2'd0) |-> $stable(strap_val)); // R3

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (seq_state != $past(seq_state)) |-> (seq_state == 2'd0 || (seq_state - $past(seq_state)) == 2'd1)); // R4

  AST_OUTS_RUN: assert property (@(posedge clk) disable iff (rst)
    outs_en |-> (seq_state == 2'd3)); // R5

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 2'd3 && supply_s) |=> (seq_state == 2'd3)); // R6

  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (rst)
    !supply_s |=> (seq_state == 2'd0 && strap_val == 2'd0)); // R7

endmodule

bind clkgen_powerup_seq clkgen_powerup_seq_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .supply_s    (supply_s),
  .vco_en      (vco_en),
  .outs_en     (outs_en),
  .strap_strobe(strap_strobe),
  .strap_val   (strap_val),
  .seq_state   (seq_state)
);

// File: tb/test_clkgen_powerup_seq.sv
module test_clkgen_powerup_seq;

  localparam int SETTLE = 6;
  localparam int LOCK   = 9;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic pwrgd_n = 1'b1;
  logic strap_a = 1'b0;
  logic strap_b = 1'b0;
  logic vco_en, strap_strobe, outs_en;
  logic [1:0] strap_val, seq_state;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  clkgen_powerup_seq #(.SETTLE_CYC(SETTLE), .LOCK_CYC(LOCK)) i_clkgen_powerup_seq (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .pwrgd_n(pwrgd_n),
    .strap_a(strap_a), .strap_b(strap_b), .vco_en(vco_en),
    .strap_strobe(strap_strobe), .strap_val(strap_val),
    .outs_en(outs_en), .seq_state(seq_state)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic chk_all(input int st, input bit strobe, input logic [1:0] sv, input string ctx);
    chk(seq_state == 2'(st), {"R4 state ", ctx}, seq_state, st);
    chk(vco_en == (st != 0), {"R2 vco_en ", ctx}, vco_en, st != 0);
    chk(outs_en == (st == 3), {"R5 outs_en ", ctx}, outs_en, st == 3);
    chk(strap_strobe == strobe, {"R3 strobe ", ctx}, strap_strobe, strobe);
    chk(strap_val == sv, {"R3 strap_val ", ctx}, strap_val, sv);
  endtask

  // one power-up run; d = negedge index at which pwrgd_n falls,
  // m = negedge index at which the supply is dropped (0 = no abort)
  task automatic run_case(input logic [1:0] sv, input int d, input int m);
    int k, last, st, base;
    bit strobe;
    logic [1:0] exp_sv;
    k = (3 + SETTLE > d + 3) ? 3 + SETTLE : d + 3;
    last = (m > 0) ? m + 5 : k + LOCK + 1;
    @(negedge clk);
    strap_a = sv[0];
    strap_b = sv[1];
    supply_ok = 1'b1;
    if (d == 0) pwrgd_n = 1'b0;
    for (int n = 1; n <= last; n++) begin
      @(negedge clk);
      base = (n < 3) ? 0 : (n < k) ? 1 : (n < k + LOCK) ? 2 : 3;
      st = base;
      strobe = (n == k);
      exp_sv = (base >= 2) ? sv : 2'b00;
      if (m > 0 && n >= m + 3) begin
        st = 0; strobe = 1'b0; exp_sv = 2'b00; // R7 abort
      end
      chk_all(st, strobe, exp_sv, (m > 0) ? "abort" : "R8 sweep");
      if (n == d) pwrgd_n = 1'b0;
      if (m > 0 && n == m) supply_ok = 1'b0;
    end
    if (m == 0) begin
      // R6: in run, toggle power-good and straps
      for (int n = 0; n < 8; n++) begin
        pwrgd_n = ~pwrgd_n;
        strap_a = ~strap_a;
        strap_b = n[0];
        @(negedge clk);
        chk(seq_state == 2'd3, "R6 state held", seq_state, 3);
        chk(outs_en == 1'b1, "R6 outs_en held", outs_en, 1);
        chk(strap_val == sv, "R6 strap_val held", strap_val, sv);
      end
      supply_ok = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(seq_state == 2'd3, "R8 loss latency", seq_state, 3);
      @(negedge clk);
      chk(seq_state == 2'd0, "R7 off after loss", seq_state, 0);
      chk(strap_val == 2'b00, "R7 straps cleared", strap_val, 0);
      chk(vco_en == 1'b0, "R1 vco off", vco_en, 0);
    end
    supply_ok = 1'b0;
    pwrgd_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_all(0, 1'b0, 2'b00, "R1 idle");
  endtask

  initial begin
    int dl[6] = '{0, 3, 6, 7, 9, 12};
    repeat (4) @(negedge clk);
    chk_all(0, 1'b0, 2'b00, "R1 in reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk_all(0, 1'b0, 2'b00, "R1 after reset");
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < 6; j++) begin
        run_case(2'(s), dl[j], 0);
      end
    end
    run_case(2'b10, 0, 1);                 // R7 inside synchroniser window
    run_case(2'b01, 0, 5);                 // R7 during wait
    run_case(2'b11, 0, 3 + SETTLE + 3);    // R7 during sampling
    run_case(2'b11, 10, 4 + SETTLE + LOCK + 3); // R7 in run (late pgood)
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule